// File: doc/BRIEF.md
# Multi-Channel Event Timer

A memory-mapped event timer. It holds one free-running 32-bit main counter and a small set of comparator channels. Each channel compares its match value with the counter and signals an interrupt when the two are equal. A channel can fire once (one-shot) or can reload itself by a fixed period after each match (periodic). The interrupt can be a level held until software clears it, or a single-cycle pulse. Each channel steers its interrupt to one of 32 IRQ lines through a route field. A legacy-route switch instead pins channels 0 and 1 to lines 0 and 8.

Software uses a simple 32-bit register port. A write takes effect at the clock edge on which it is presented. A read returns data in the same cycle. The counter is loaded while the timer is stopped. Software then arms the channels and sets the global enable.

Register offsets:

- 0x00: capabilities
- 0x04: tick period in femtoseconds
- 0x08: general configuration (bit 0 is enable, bit 1 is legacy route)
- 0x0C: interrupt status
- 0x10: main counter

Channel n occupies 0x20+0x10·n. Within that block, +0 is configuration, +4 is the comparator and +8 is the route-mask word.

Top module: `evtimer_core`

## Requirements
- R1: The capabilities word reads vendor in [31:16], legacy-capable in bit 15, 0 in bits 14:13, channel count minus one in [12:8] and revision in [7:0]. The period word reads the non-zero PERIOD_FS. Each channel's +8 word reads ROUTE_MASK. Channel configuration reads bit 4 = periodic-capable, bit 8 = 1 (32-bit mode), bits 5 and 15 = 0. After reset, comparators read 0xFFFFFFFF and all other writable state reads 0.
- R2: While general-configuration bit 0 is set, the counter rises by one every clock. While that bit is clear, the counter holds its value.
- R3: A write to the counter at 0x10 loads it only while the enable is clear. Such a write made while the timer runs is ignored, and counting continues.
- R4: A match is exact equality of counter and comparator while the timer runs. In one-shot mode a match leaves the comparator unchanged, so the channel fires once.
- R5: In periodic mode (channel configuration bit 3) each match adds the period to the comparator. This also happens when the channel's interrupt enable is clear.
- R6: When the periodic bit and the value-set bit (bit 6) are both set, the next comparator write loads the match value and clears value-set. The write after that loads the period.
- R7: In level mode (bit 1 = 1) a match sets the channel's status bit. That status bit holds the routed line high. Writing 1 to the bit at 0x0C clears it; writing 0 has no effect.
- R8: In edge mode (bit 1 = 0) each match gives a one-cycle pulse on the routed line and leaves the status bit clear.
- R9: The route field in bits 13:9 selects the IRQ line. With general-configuration bit 1 set, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold.
- R10: On a channel without periodic capability, the periodic and value-set bits are ignored. They read 0, and the channel stays one-shot.
- R11: With the interrupt-enable bit (bit 2) clear, a match neither sets status nor drives a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| irq_lines | output | 32 | Interrupt lines |

## Verification
The hardest state to reach is a periodic channel several reloads into its run, with a period loaded by the two-write value-set sequence. No port shows the period directly. The bench stops the timer, loads the counter to a known value, and runs the two-write sequence. It then enables the timer for an exact number of clocks. From that count it works out how many pulses must have appeared and where the comparator must end up. Legacy routing is checked with level-held status, so that switching the routing mode moves the same active interrupts to new lines.

// File: rtl/evtimer_core.sv
module evtimer_core #(
  parameter int              NUM_CH     = 3,
  parameter logic [15:0]     VENDOR     = 16'h1a2b,
  parameter logic [7:0]      REV        = 8'h01,
  parameter logic [31:0]     PERIOD_FS  = 32'd10_000_000,
  parameter logic [31:0]     ROUTE_MASK = 32'h00ff_ff79,
  parameter logic [NUM_CH-1:0] PER_CAP  = 3'b011,
  parameter bit              LEG_CAP    = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [31:0] irq_lines
);
  localparam logic [7:0] A_CAP = 8'h00, A_PRD = 8'h04, A_CFG = 8'h08;
  localparam logic [7:0] A_STS = 8'h0c, A_CNT = 8'h10;
  localparam int CH_BASE = 32, CH_STRIDE = 16;

  logic [31:0] cnt;
  logic run, leg;
  logic [NUM_CH-1:0] sts, pulse, ien, lvl, per, vset, pnext, hit, wcfg, wcmp;
  logic [4:0]  route [NUM_CH];
  logic [4:0]  dest  [NUM_CH];
  logic [31:0] cmp   [NUM_CH];
  logic [31:0] prd   [NUM_CH];

  wire wr_sts = reg_wr && reg_addr == A_STS;
  wire wr_cnt = reg_wr && reg_addr == A_CNT;
  wire wr_gcf = reg_wr && reg_addr == A_CFG;

  always_comb
    for (int c = 0; c < NUM_CH; c++) begin
      hit[c]  = run && cnt == cmp[c];
      wcfg[c] = reg_wr && reg_addr == 8'(CH_BASE + CH_STRIDE * c);
      wcmp[c] = reg_wr && reg_addr == 8'(CH_BASE + CH_STRIDE * c + 4);
      if (leg && c == 0)      dest[c] = 5'd0;
      else if (leg && c == 1) dest[c] = 5'd8;
      else                    dest[c] = route[c];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; run <= 1'b0; leg <= 1'b0;
      sts <= '0; pulse <= '0; ien <= '0; lvl <= '0;
      per <= '0; vset <= '0; pnext <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        route[c] <= '0; cmp[c] <= '1; prd[c] <= '0;
      end
    end else begin
      if (wr_gcf) begin
        run <= reg_wdata[0];
        leg <= reg_wdata[1] & LEG_CAP;
      end
      if (wr_cnt && !run) cnt <= reg_wdata;
      else if (run)       cnt <= cnt + 32'd1;
      for (int c = 0; c < NUM_CH; c++) begin
        sts[c]   <= (sts[c] & ~(wr_sts & reg_wdata[c])) | (hit[c] & ien[c] & lvl[c]);
        pulse[c] <= hit[c] & ien[c] & ~lvl[c];
        if (hit[c] && per[c]) cmp[c] <= cmp[c] + prd[c];
        if (wcfg[c]) begin
          lvl[c]   <= reg_wdata[1];
          ien[c]   <= reg_wdata[2];
          per[c]   <= reg_wdata[3] & PER_CAP[c];
          vset[c]  <= reg_wdata[6] & reg_wdata[3] & PER_CAP[c];
          route[c] <= reg_wdata[13:9];
          pnext[c] <= 1'b0;
        end
        if (wcmp[c]) begin
          if (pnext[c]) begin
            prd[c]   <= reg_wdata;
            pnext[c] <= 1'b0;
          end else begin
            cmp[c] <= reg_wdata;
            if (vset[c]) begin
              vset[c]  <= 1'b0;
              pnext[c] <= 1'b1;
            end
          end
        end
      end
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CAP: reg_rdata = {VENDOR, LEG_CAP, 2'b00, 5'(NUM_CH - 1), REV};
      A_PRD: reg_rdata = PERIOD_FS;
      A_CFG: reg_rdata = {30'd0, leg, run};
      A_STS: reg_rdata = 32'(sts);
      A_CNT: reg_rdata = cnt;
      default: ;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == 8'(CH_BASE + CH_STRIDE * c))
        reg_rdata = {16'h0, 2'b00, route[c], 1'b1, 1'b0, vset[c], 1'b0,
                     PER_CAP[c], per[c], ien[c], lvl[c], 1'b0};
      if (reg_addr == 8'(CH_BASE + CH_STRIDE * c + 4)) reg_rdata = cmp[c];
      if (reg_addr == 8'(CH_BASE + CH_STRIDE * c + 8)) reg_rdata = ROUTE_MASK;
    end
  end

  always_comb begin
    irq_lines = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (sts[c] | pulse[c]) irq_lines[dest[c]] = 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + 32'd1); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt)); // R2
  AST_CNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_cnt) |=> cnt == $past(cnt) + 32'd1); // R3

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_PER_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && per[g] && !wcmp[g]) |=> cmp[g] == $past(cmp[g]) + $past(prd[g])); // R5
    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && !per[g] && !wcmp[g]) |=> $stable(cmp[g])); // R4
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[g] && !(wr_sts && reg_wdata[g])) |=> sts[g]); // R7
    AST_EDGE_NO_STS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts[g] && !lvl[g]) |=> !sts[g]); // R8
    AST_VSET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (vset[g] && wcmp[g]) |=> (!vset[g] && pnext[g])); // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien[g] && !sts[g]) |=> (!pulse[g] && !sts[g])); // R11
    if (!PER_CAP[g]) begin : g_noper
      AST_NO_PERIODIC: assert property (@(posedge clk) disable iff (!rst_n)
        !per[g] && !vset[g]); // R10
    end
  end
endmodule

// File: tb/evtimer_core_tb.sv
module evtimer_core_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, irq_lines;
  int n_chk = 0, n_fail = 0, hi5 = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  evtimer_core dut_i (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
                      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines));

  always @(negedge clk) if (irq_lines[5]) hi5++;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    rd(8'h00, v); chk("R1 caps", v, 32'h1a2b_8201);
    rd(8'h04, v); chk("R1 period", v, 32'd10_000_000);
    rd(8'h28, v); chk("R1 route mask", v, 32'h00ff_ff79);
    rd(8'h20, v); chk("R1 ch0 cfg", v, 32'h0000_0110);
    rd(8'h40, v); chk("R1 ch2 cfg", v, 32'h0000_0100);
    rd(8'h24, v); chk("R1 cmp reset", v, 32'hffff_ffff);
    rd(8'h10, v); chk("R1 counter reset", v, 32'd0);
    rd(8'h0c, v); chk("R1 status reset", v, 32'd0);
  endtask

  task automatic t_counter();
    do_reset();
    wr(8'h10, 32'd100);
    rd(8'h10, v); chk("R3 load while stopped", v, 32'd100);
    wr(8'h08, 32'd1);
    step(10);
    rd(8'h10, v); chk("R2 counting", v, 32'd110);
    wr(8'h10, 32'd5);
    rd(8'h10, v); chk("R3 write ignored while running", v, 32'd111);
    wr(8'h08, 32'd0);
    rd(8'h10, v); chk("R2 stop", v, 32'd112);
    step(5);
    rd(8'h10, v); chk("R2 frozen", v, 32'd112);
  endtask

  task automatic t_oneshot_level();
    do_reset();
    wr(8'h20, (32'd3 << 9) | 32'h6);
    wr(8'h24, 32'd20);
    wr(8'h08, 32'd1);
    step(15);
    rd(8'h0c, v); chk("R4 no early match", v, 32'd0);
    chk("R4 line low before match", irq_lines, 32'd0);
    step(10);
    rd(8'h0c, v); chk("R7 status set", v, 32'd1);
    chk("R7 line held", irq_lines, 32'h8);
    rd(8'h24, v); chk("R4 one-shot comparator kept", v, 32'd20);
    wr(8'h0c, 32'h2);
    rd(8'h0c, v); chk("R7 write 0 no effect", v, 32'd1);
    step(20);
    chk("R7 line still held", irq_lines, 32'h8);
    wr(8'h0c, 32'h1);
    rd(8'h0c, v); chk("R7 write 1 clears", v, 32'd0);
    chk("R7 line released", irq_lines, 32'd0);
    step(50);
    rd(8'h0c, v); chk("R4 fires once", v, 32'd0);
  endtask

  task automatic t_edge_periodic();
    do_reset();
    wr(8'h30, (32'd5 << 9) | 32'h4c);
    wr(8'h34, 32'd10);
    rd(8'h30, v); chk("R6 value-set clears", v & 32'h40, 32'd0);
    wr(8'h34, 32'd7);
    rd(8'h34, v); chk("R6 first write is match value", v, 32'd10);
    hi5 = 0;
    wr(8'h08, 32'd1);
    step(40);
    chk("R8 one pulse cycle per match", 32'(hi5), 32'd5);
    rd(8'h0c, v); chk("R8 edge leaves status clear", v, 32'd0);
    rd(8'h34, v); chk("R5 comparator advanced by period", v, 32'd45);
  endtask

  task automatic t_periodic_noint();
    do_reset();
    wr(8'h20, 32'h4a);
    wr(8'h24, 32'd3);
    wr(8'h24, 32'd4);
    wr(8'h08, 32'd1);
    step(20);
    rd(8'h24, v); chk("R5 reload without interrupt enable", v, 32'd23);
    rd(8'h0c, v); chk("R11 no status", v, 32'd0);
    chk("R11 no line", irq_lines, 32'd0);
  endtask

  task automatic t_legacy();
    do_reset();
    wr(8'h20, (32'd3 << 9) | 32'h6);
    wr(8'h24, 32'd2);
    wr(8'h30, (32'd4 << 9) | 32'h6);
    wr(8'h34, 32'd2);
    wr(8'h08, 32'd3);
    step(5);
    chk("R9 legacy lines 0 and 8", irq_lines, 32'h101);
    wr(8'h08, 32'd1);
    chk("R9 route fields", irq_lines, 32'h18);
    wr(8'h0c, 32'h3);
    chk("R7 both cleared", irq_lines, 32'd0);
  endtask

  task automatic t_noperiodic();
    do_reset();
    wr(8'h40, (32'd6 << 9) | 32'h4e);
    rd(8'h40, v); chk("R10 periodic bits read 0", v & 32'h58, 32'd0);
    wr(8'h44, 32'd5);
    wr(8'h44, 32'd9);
    rd(8'h44, v); chk("R10 no period sequence", v, 32'd9);
    wr(8'h08, 32'd1);
    step(15);
    rd(8'h0c, v); chk("R10 one-shot match", v, 32'h4);
    chk("R9 routed to line 6", irq_lines, 32'h40);
    rd(8'h44, v); chk("R10 comparator not advanced", v, 32'd9);
  endtask

  initial begin
    t_reset();
    t_counter();
    t_oneshot_level();
    t_edge_periodic();
    t_periodic_noint();
    t_legacy();
    t_noperiodic();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule